// File: doc/BRIEF.md
# CPU Clock Prescaler with High-Phase Stretching

This block slows the CPU core's timebase relative to the system clock. It does this with a clock-enable pulse and never gates a clock. A 3-bit prescale code sets the ratio. Code 0 lets every system-clock cycle through to the CPU. A nonzero code N gives one CPU cycle every N+1 system-clock cycles. Peripherals keep their own enable, and that enable stays high at the full system rate whatever the code is.

The block also has a level indicator that shows the shape of the derived CPU clock. It is low only in the last system-clock cycle of each CPU period, and that is the cycle in which the enable pulse fires. The waveform therefore does not keep a 50% duty cycle: the high phase takes up every skipped cycle.

An external-memory wait or a bus-request hold stretches the high phase further, for as long as either is asserted, with no upper limit. A new prescale code is picked up only at the end of the CPU period in progress, so a code change never produces a shortened period.

Top module: `cpu_clk_prescaler`

## Requirements
- R1: With the prescale code at 0 in effect and no wait or bus request, `cpu_en` is high and `cpu_clk_hi` is low in every system-clock cycle.
- R2: With a nonzero code N in effect and no stall, `cpu_en` is high in exactly one cycle out of every N+1, so the ratios run from 2 (code 1) to 8 (code 7).
- R3: Within each period under code N, `cpu_clk_hi` is high for N cycles and then low for one cycle. The low cycle is the cycle in which `cpu_en` is high.
- R4: In any cycle where `mem_wait` or `bus_hold` is high, `cpu_en` is low and `cpu_clk_hi` is high.
- R5: Each cycle with `mem_wait` or `bus_hold` high pauses period progress, at any point in the period including its final cycle. The period in progress is lengthened by exactly that many cycles.
- R6: `presc_code` is sampled only in a cycle where `cpu_en` is high. That value sets the length of the next period, and the period in progress completes at its old length.
- R7: While `rst_n` is low, `cpu_en` and `periph_en` are low and `cpu_clk_hi` is high. The code in effect after reset is 0, so the first cycle after release carries a `cpu_en` pulse and samples `presc_code`.
- R8: `periph_en` is high in every cycle after reset, whatever the code, `mem_wait` and `bus_hold` are doing.
- R9: With code 0 in effect, a wait or bus request suppresses `cpu_en` only in the cycles where the request is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| presc_code | input | 3 | Prescale code; ratio is code+1, 0 means no prescaling |
| mem_wait | input | 1 | External-memory wait request, stretches the high phase |
| bus_hold | input | 1 | Bus-request hold, stretches the high phase |
| cpu_en | output | 1 | CPU clock-enable pulse, one per CPU period |
| cpu_clk_hi | output | 1 | Level of the derived CPU clock (1 = high phase) |
| periph_en | output | 1 | Peripheral enable, high every cycle out of reset |

## Verification
The bench sweeps all eight codes with the stall inputs quiet. For each code it measures the spacing of the pulses and the number of high cycles, which separates an off-by-one ratio from a wrong duty shape. It then places stalls early in a period and on the final cycle of a period. The first placement tells a paused counter from a restarted one. The second tells a delayed pulse from a dropped one.

A mid-period code change shows whether the code is latched only at the period boundary. A long pseudo-random stream of codes and requests is then compared slot by slot with a model built from the requirements. Code 0 with stalls is included to show that suppression is confined to the stalled cycles.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;
  localparam int unsigned CODE_W_DEF = 3;

  typedef enum logic [0:0] {
    PH_HIGH = 1'b0,
    PH_LOW  = 1'b1
  } cpu_phase_e;
endpackage

// File: rtl/cpuclk_stall_merge.sv
module cpuclk_stall_merge #(
  parameter int N_SRC = 2
) (
  input  logic [N_SRC-1:0] req,
  output logic             stall
);
  logic [N_SRC:0] chain;

  assign chain[0] = 1'b0;

  generate
    for (genvar i = 0; i < N_SRC; i++) begin : g_or
      assign chain[i+1] = chain[i] | req[i];
    end
  endgenerate

  assign stall = chain[N_SRC];
endmodule

// File: rtl/cpuclk_period_cnt.sv
module cpuclk_period_cnt #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_in,
  input  logic              stall,
  output logic              last,
  output logic [CODE_W-1:0] act_code
);
  logic [CODE_W-1:0] cnt;
  logic              wrap;

  assign last = (cnt == act_code);
  assign wrap = last & ~stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      act_code <= '0;
    end else if (wrap) begin
      cnt      <= '0;
      act_code <= code_in;
    end else if (!stall) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= act_code); // R2

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (cnt == $past(cnt))); // R5

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> (act_code == $past(act_code))); // R6
endmodule

// File: rtl/cpuclk_phase_out.sv
module cpuclk_phase_out
  import cpuclk_pkg::*;
(
  input  logic rst_n,
  input  logic last,
  input  logic stall,
  output logic cpu_en,
  output logic cpu_clk_hi
);
  cpu_phase_e phase;

  always_comb begin
    if (rst_n && last && !stall) phase = PH_LOW;
    else                         phase = PH_HIGH;
  end

  assign cpu_en     = (phase == PH_LOW);
  assign cpu_clk_hi = (phase == PH_HIGH);
endmodule

// File: rtl/cpu_clk_prescaler.sv
module cpu_clk_prescaler #(
  parameter int CODE_W = cpuclk_pkg::CODE_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] presc_code,
  input  logic              mem_wait,
  input  logic              bus_hold,
  output logic              cpu_en,
  output logic              cpu_clk_hi,
  output logic              periph_en
);
  localparam int N_STALL = 2;

  logic [N_STALL-1:0] stall_req;
  logic               stall;
  logic               last;
  logic [CODE_W-1:0]  act_code;

  assign stall_req = {bus_hold, mem_wait};

  cpuclk_stall_merge #(.N_SRC(N_STALL)) u_merge (
    .req   (stall_req),
    .stall (stall)
  );

  cpuclk_period_cnt #(.CODE_W(CODE_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .code_in  (presc_code),
    .stall    (stall),
    .last     (last),
    .act_code (act_code)
  );

  cpuclk_phase_out u_phase (
    .rst_n      (rst_n),
    .last       (last),
    .stall      (stall),
    .cpu_en     (cpu_en),
    .cpu_clk_hi (cpu_clk_hi)
  );

  assign periph_en = rst_n;

  AST_STALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wait || bus_hold) |-> (cpu_clk_hi && !cpu_en)); // R4

  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    (act_code == '0 && !mem_wait && !bus_hold) |-> cpu_en); // R1
endmodule

// File: tb/test_cpu_clk_prescaler.sv
`timescale 1ns/1ps
module test_cpu_clk_prescaler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] presc_code = 3'd0;
  logic       mem_wait = 1'b0;
  logic       bus_hold = 1'b0;
  logic       cpu_en, cpu_clk_hi, periph_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int cur = 0;
  int k = 0;

  cpu_clk_prescaler i_cpu_clk_prescaler (
    .clk(clk), .rst_n(rst_n), .presc_code(presc_code),
    .mem_wait(mem_wait), .bus_hold(bus_hold),
    .cpu_en(cpu_en), .cpu_clk_hi(cpu_clk_hi), .periph_en(periph_en)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One system-clock slot: drive at negedge, sample 1 ns later, compare with model.
  task automatic run_slot(input logic w, input logic b, input int c);
    bit stl, xe;
    string tag;
    @(negedge clk);
    mem_wait = w; bus_hold = b; presc_code = c[2:0];
    #1;
    stl = w | b;
    xe  = !stl && (k == cur);
    if (stl)           tag = (cur == 0) ? "R9" : "R4";
    else if (cur == 0) tag = "R1";
    else               tag = "R3";
    chk({tag, " cpu_en"}, cpu_en, xe);
    chk({tag, " cpu_clk_hi"}, cpu_clk_hi, !xe);
    chk("R8 periph_en", periph_en, 1);
    if (xe) begin k = 0; cur = c; end
    else if (!stl) k++;
  endtask

  // Run with code c until a pulse; returns slot count.
  task automatic to_pulse(input int c, output int slots, output int highs);
    slots = 0; highs = 0;
    do begin
      run_slot(1'b0, 1'b0, c);
      slots++;
      if (cpu_clk_hi) highs++;
    end while (!cpu_en && slots < 64);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int sl, hi;
    logic [15:0] lfsr;
    // R7: reset state
    repeat (3) @(negedge clk);
    #1;
    chk("R7 cpu_en in reset", cpu_en, 0);
    chk("R7 cpu_clk_hi in reset", cpu_clk_hi, 1);
    chk("R7 periph_en in reset", periph_en, 0);
    @(negedge clk);
    rst_n = 1'b1; presc_code = 3'd5;
    #1;
    chk("R7 first slot pulse", cpu_en, 1);
    chk("R8 periph_en after reset", periph_en, 1);
    cur = 5; k = 0;
    to_pulse(5, sl, hi);
    chk("R7 first programmed period", sl, 6);

    // R2/R3: sweep of every code
    for (int c = 0; c < 8; c++) begin
      to_pulse(c, sl, hi);
      to_pulse(c, sl, hi);
      chk("R2 period length", sl, c + 1);
      chk("R3 high cycles", hi, c);
      to_pulse(c, sl, hi);
      chk("R2 repeat period", sl, c + 1);
    end

    // R5: stalls mid-period and on the final slot
    for (int c = 0; c < 8; c++) begin
      to_pulse(c, sl, hi);
      to_pulse(c, sl, hi);
      sl = 0;
      run_slot(1'b1, 1'b0, c); sl++;
      run_slot(1'b1, 1'b0, c); sl++;
      run_slot(1'b0, 1'b1, c); sl++;
      while (!cpu_en && sl < 64) begin run_slot(1'b0, 1'b0, c); sl++; end
      chk("R5 stalled period length", sl, c + 1 + 3);
    end
    to_pulse(3, sl, hi);
    to_pulse(3, sl, hi);
    for (int i = 0; i < 3; i++) run_slot(1'b0, 1'b0, 3);
    run_slot(1'b1, 1'b0, 3);
    chk("R5 pulse held by stall on last slot", cpu_en, 0);
    run_slot(1'b0, 1'b1, 3);
    chk("R5 pulse held by bus hold", cpu_en, 0);
    run_slot(1'b0, 1'b0, 3);
    chk("R5 pulse after release", cpu_en, 1);

    // R9: code 0 with stalls
    to_pulse(0, sl, hi);
    to_pulse(0, sl, hi);
    run_slot(1'b1, 1'b1, 0);
    chk("R9 suppressed while stalled", cpu_en, 0);
    run_slot(1'b0, 1'b0, 0);
    chk("R9 pulse resumes", cpu_en, 1);

    // R6: mid-period code change
    to_pulse(6, sl, hi);
    to_pulse(6, sl, hi);
    run_slot(1'b0, 1'b0, 6);
    sl = 1;
    while (sl < 64) begin
      run_slot(1'b0, 1'b0, 1); sl++;
      if (cpu_en) break;
    end
    chk("R6 old ratio completes", sl, 7);
    to_pulse(1, sl, hi);
    chk("R6 new ratio after boundary", sl, 2);

    // Pseudo-random stream against the requirement model
    lfsr = 16'hACE1;
    for (int i = 0; i < 1500; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      run_slot(lfsr[3:0] == 4'd0, lfsr[7:4] == 4'd1, int'(lfsr[10:8]));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule